// File: doc/BRIEF.md
# Fuse Read Window Guard

This block sits between the read sequencer of a one-time-programmable fuse array and the array itself. Every read request is compared against a programmable address window. A request inside the window, while guarding is on, never reaches the array. It completes one cycle later with all-zero data and raises a sticky violation flag. A request outside the window is passed through unchanged, and the array's answer is returned as it arrives.

Software programs the window over a zero-wait APB slave with three words. Word 0 holds the low bound, word 1 the high bound, and word 2 the control and status bits. The first write to the high bound seals both bounds until the power-on reset input is asserted. The ordinary bus reset does not clear the seal. This lets boot firmware fix a secret region once, so later software cannot reopen it.

Top module: `fuse_read_window_guard`

## Requirements
- R1: After power-on reset (`por_n` low), word 0, word 1 and word 2 all read as zero.
- R2: Register map, selected by `paddr[3:2]`. Word 0 is the low bound in bits [15:0]. Word 1 is the high bound in bits [15:0]. Word 2 holds guard enable in bit 0 (read-write), the seal flag in bit 1 (read-only), and the violation flag in bit 2 (write 1 to clear). All other bits read as zero. Before sealing, both bounds read back what was last written.
- R3: A write to word 1 while unsealed stores the high bound and sets the seal. Once sealed, writes to word 0 and word 1 are ignored without any error, and reads of them return the stored values.
- R4: The seal and both bounds are kept through a `presetn` pulse. Only `por_n` clears them.
- R5: With guard enable at 1 and `lo <= rd_addr <= hi` (both ends inclusive), a request raises no `mac_req`.
- R6: A denied request gives `rd_done` high in the next cycle with `rd_data` equal to zero.
- R7: An allowed request drives `mac_req` in the same cycle with `mac_addr == rd_addr`. `rd_done` and `rd_data` follow `mac_done` and `mac_data` in the cycle they arrive.
- R8: A denial sets the violation flag, which stays set until a write of 1 to word 2 bit 2, or a reset. If a denial and a clear happen in the same cycle, the flag stays set.
- R9: With guard enable at 0, or with `lo > hi`, every request is allowed.
- R10: `presetn` clears guard enable and the violation flag.

Design note for R2: a write to word 2 updates guard enable from bit 0 at the same time as it acts on the bit 2 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and guard clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including the seal |
| presetn | input | 1 | Bus reset, active low, clears enable and violation only |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | PAW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| rd_req | input | 1 | Read request from the sequencer |
| rd_addr | input | AW | Requested fuse address |
| rd_done | output | 1 | Read completion pulse |
| rd_data | output | DW | Read result, zero when denied |
| mac_req | output | 1 | Request forwarded to the fuse array |
| mac_addr | output | AW | Address forwarded to the fuse array |
| mac_done | input | 1 | Completion from the fuse array |
| mac_data | input | DW | Data from the fuse array |

## Verification
If the window compare is off by one at either bound, `mac_req` rises in the very cycle the boundary address is presented, or fails to rise when it should. A wrong seal state shows up on the next readback of word 0 or word 1 after a rejected write. It also shows in word 2 bit 1, immediately after the high-bound write and again after a bus reset. A lost or stuck denial register appears one cycle after the request, as a missing `rd_done` or nonzero `rd_data`. The violation flag is checked by readback after a denial, after a clear, and after a clear that lands in the same cycle as a denial.

// File: rtl/fuse_guard_pkg.sv
package fuse_guard_pkg;
  localparam int WORD_SEL_LSB = 2;
  localparam logic [1:0] WORD_LO  = 2'd0;
  localparam logic [1:0] WORD_HI  = 2'd1;
  localparam logic [1:0] WORD_CTL = 2'd2;
  localparam int CTL_EN   = 0;
  localparam int CTL_SEAL = 1;
  localparam int CTL_VIOL = 2;
endpackage

// File: rtl/fuse_guard_regs.sv
module fuse_guard_regs
  import fuse_guard_pkg::*;
#(
  parameter int AW  = 16,
  parameter int PAW = 4
) (
  input  logic          pclk,
  input  logic          por_n,
  input  logic          soft_rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [PAW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  input  logic          deny_evt,
  output logic [AW-1:0] win_lo,
  output logic [AW-1:0] win_hi,
  output logic          win_en
);
  logic [AW-1:0] lo_q, hi_q;
  logic          seal_q, en_q, viol_q;
  logic [1:0]    word;
  logic          wr_acc, lo_wr, hi_wr, ctl_wr, seal_evt, viol_clr;

  assign word     = paddr[WORD_SEL_LSB +: 2];
  assign wr_acc   = psel & penable & pwrite;
  assign lo_wr    = wr_acc && (word == WORD_LO);
  assign hi_wr    = wr_acc && (word == WORD_HI);
  assign ctl_wr   = wr_acc && (word == WORD_CTL);
  assign seal_evt = hi_wr && !seal_q;
  assign viol_clr = ctl_wr && pwdata[CTL_VIOL];

  always_ff @(posedge pclk or negedge por_n) begin
    if (!por_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      seal_q <= 1'b0;
    end else begin
      if (lo_wr && !seal_q) lo_q <= pwdata[AW-1:0];
      if (seal_evt) begin
        hi_q   <= pwdata[AW-1:0];
        seal_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge pclk or negedge soft_rst_n) begin
    if (!soft_rst_n) begin
      en_q   <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      if (ctl_wr) en_q <= pwdata[CTL_EN];
      if (deny_evt)      viol_q <= 1'b1;
      else if (viol_clr) viol_q <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (word)
        WORD_LO:  prdata[AW-1:0] = lo_q;
        WORD_HI:  prdata[AW-1:0] = hi_q;
        WORD_CTL: begin
          prdata[CTL_EN]   = en_q;
          prdata[CTL_SEAL] = seal_q;
          prdata[CTL_VIOL] = viol_q;
        end
        default:  prdata = '0;
      endcase
    end
  end

  assign win_lo = lo_q;
  assign win_hi = hi_q;
  assign win_en = en_q;

  a_r3_lo_frozen: assert property (@(posedge pclk) disable iff (!por_n)
    seal_q |=> $stable(lo_q));
  a_r3_hi_frozen: assert property (@(posedge pclk) disable iff (!por_n)
    seal_q |=> $stable(hi_q));
  a_r4_seal_holds: assert property (@(posedge pclk) disable iff (!por_n)
    seal_q |=> seal_q);
  a_r3_seal_on_hi: assert property (@(posedge pclk) disable iff (!por_n)
    hi_wr |=> seal_q);
  a_r8_viol_sticky: assert property (@(posedge pclk) disable iff (!soft_rst_n)
    (viol_q && !viol_clr) |=> viol_q);
  a_r8_viol_set: assert property (@(posedge pclk) disable iff (!soft_rst_n)
    deny_evt |=> viol_q);
endmodule

// File: rtl/fuse_guard_gate.sv
module fuse_guard_gate #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          pclk,
  input  logic          soft_rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] win_lo,
  input  logic [AW-1:0] win_hi,
  input  logic          win_en,
  output logic          mac_req,
  output logic [AW-1:0] mac_addr,
  input  logic          mac_done,
  input  logic [DW-1:0] mac_data,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          deny_evt
);
  function automatic logic in_window(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                     input logic [AW-1:0] hi, input logic en);
    return en && (a >= lo) && (a <= hi);
  endfunction

  logic hit, deny_q;

  assign hit      = in_window(rd_addr, win_lo, win_hi, win_en);
  assign deny_evt = rd_req & hit;
  assign mac_req  = rd_req & ~hit;
  assign mac_addr = rd_addr;

  always_ff @(posedge pclk or negedge soft_rst_n) begin
    if (!soft_rst_n) deny_q <= 1'b0;
    else             deny_q <= deny_evt;
  end

  assign rd_done = deny_q | mac_done;
  assign rd_data = deny_q ? '0 : mac_data;

  a_r5_no_forward: assert property (@(posedge pclk) disable iff (!soft_rst_n)
    deny_evt |-> !mac_req);
  a_r6_zero_done: assert property (@(posedge pclk) disable iff (!soft_rst_n)
    deny_evt |=> (rd_done && rd_data == '0));
  a_r7_pass: assert property (@(posedge pclk) disable iff (!soft_rst_n)
    (rd_req && !deny_evt) |-> (mac_req && mac_addr == rd_addr));
endmodule

// File: rtl/fuse_read_window_guard.sv
module fuse_read_window_guard #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int PAW = 4
) (
  input  logic           pclk,
  input  logic           por_n,
  input  logic           presetn,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [PAW-1:0] paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  input  logic           rd_req,
  input  logic [AW-1:0]  rd_addr,
  output logic           rd_done,
  output logic [DW-1:0]  rd_data,
  output logic           mac_req,
  output logic [AW-1:0]  mac_addr,
  input  logic           mac_done,
  input  logic [DW-1:0]  mac_data
);
  logic          soft_rst_n;
  logic [AW-1:0] win_lo, win_hi;
  logic          win_en, deny_evt;

  assign soft_rst_n = presetn & por_n;

  fuse_guard_regs #(.AW(AW), .PAW(PAW)) u_regs (
    .pclk(pclk), .por_n(por_n), .soft_rst_n(soft_rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .deny_evt(deny_evt),
    .win_lo(win_lo), .win_hi(win_hi), .win_en(win_en)
  );

  fuse_guard_gate #(.AW(AW), .DW(DW)) u_gate (
    .pclk(pclk), .soft_rst_n(soft_rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .win_lo(win_lo), .win_hi(win_hi), .win_en(win_en),
    .mac_req(mac_req), .mac_addr(mac_addr), .mac_done(mac_done),
    .mac_data(mac_data), .rd_done(rd_done), .rd_data(rd_data),
    .deny_evt(deny_evt)
  );
endmodule

// File: tb/fuse_read_window_guard_tb_top.sv
module fuse_read_window_guard_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, presetn = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        rd_req = 0;
  logic [15:0] rd_addr = '0;
  logic        rd_done, mac_req, mac_done;
  logic [7:0]  rd_data, mac_data;
  logic [15:0] mac_addr;

  int checks = 0, fails = 0;
  bit finished = 0;
  string rd_tag = "R2";

  // reference state
  int m_lo, m_hi, m_en, m_seal, m_viol, m_pend, m_pdata;

  always #2 clk = ~clk;

  fuse_read_window_guard dut_i (
    .pclk(clk), .por_n(por_n), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .mac_req(mac_req), .mac_addr(mac_addr), .mac_done(mac_done), .mac_data(mac_data)
  );

  function automatic int fuse_val(int a);
    return (a & 255) ^ 8'h5A;
  endfunction

  // fuse array stand-in: answers one cycle after a request
  always @(posedge clk or negedge presetn or negedge por_n) begin
    if (!presetn || !por_n) begin
      mac_done <= 1'b0;
      mac_data <= '0;
    end else begin
      mac_done <= mac_req;
      mac_data <= 8'(fuse_val(int'(mac_addr)));
    end
  end

  function automatic int model_word(int w);
    case (w)
      0: return m_lo;
      1: return m_hi;
      2: return m_en | (m_seal << 1) | (m_viol << 2);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int hit, w;
    #1;
    if (por_n && presetn) begin
      hit = (m_en != 0) && (int'(rd_addr) >= m_lo) && (int'(rd_addr) <= m_hi);
      chk(hit ? "R5 mac_req" : "R7 mac_req", int'(mac_req), (rd_req && !hit) ? 1 : 0);
      if (rd_req && !hit) chk("R7 mac_addr", int'(mac_addr), int'(rd_addr));
      chk("R6 rd_done", int'(rd_done), m_pend);
      if (m_pend != 0) chk("R6 rd_data", int'(rd_data), m_pdata);
      if (psel && penable && !pwrite) chk(rd_tag, int'(prdata), model_word(int'(paddr[3:2])));
    end
    @(posedge clk);
    if (!por_n) begin
      m_lo = 0; m_hi = 0; m_seal = 0; m_en = 0; m_viol = 0; m_pend = 0;
    end else if (!presetn) begin
      m_en = 0; m_viol = 0; m_pend = 0;
    end else begin
      hit = rd_req && (m_en != 0) && (int'(rd_addr) >= m_lo) && (int'(rd_addr) <= m_hi);
      m_pend = rd_req ? 1 : 0;
      m_pdata = hit ? 0 : fuse_val(int'(rd_addr));
      if (psel && penable && pwrite) begin
        w = int'(paddr[3:2]);
        if (w == 0 && m_seal == 0) m_lo = int'(pwdata[15:0]);
        if (w == 1 && m_seal == 0) begin m_hi = int'(pwdata[15:0]); m_seal = 1; end
        if (w == 2) begin
          m_en = int'(pwdata[0]);
          if (pwdata[2]) m_viol = 0;
        end
      end
      if (hit) m_viol = 1;
    end
    @(negedge clk);
  endtask

  task automatic apb_wr(int a, int d);
    psel = 1; penable = 0; pwrite = 1; paddr = 4'(a); pwdata = 32'(d);
    step();
    penable = 1; step();
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(int a, string tag);
    rd_tag = tag;
    psel = 1; penable = 0; pwrite = 0; paddr = 4'(a);
    step();
    penable = 1; step();
    psel = 0; penable = 0;
  endtask

  task automatic fuse_rd(int a);
    rd_req = 1; rd_addr = 16'(a); step();
    rd_req = 0; step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    por_n = 1; presetn = 1;
    step();
    // R1 reset state
    apb_rd(0, "R1"); apb_rd(4, "R1"); apb_rd(8, "R1");
    // R2 writable bounds before sealing
    apb_wr(0, 32'hFFFF_0010); apb_rd(0, "R2");
    apb_wr(8, 1); apb_rd(8, "R2");
    // R9 lo > hi blocks nothing
    fuse_rd(16'h0010); fuse_rd(16'h0000);
    // R3 seal on high-bound write
    apb_wr(4, 16'h0020); apb_rd(4, "R3"); apb_rd(8, "R3");
    apb_wr(0, 16'h5555); apb_wr(4, 16'h7777);
    apb_rd(0, "R3 locked lo"); apb_rd(4, "R3 locked hi");
    // R5 R6 R7 boundaries
    fuse_rd(16'h000F); fuse_rd(16'h0010); fuse_rd(16'h0018);
    fuse_rd(16'h0020); fuse_rd(16'h0021);
    for (int i = 0; i < 6; i++) begin
      rd_req = 1; rd_addr = 16'(16'h000E + i * 5); step();
    end
    rd_req = 0; step();
    apb_rd(8, "R8 set");
    // R8 clear coinciding with a denial keeps flag
    psel = 1; pwrite = 1; paddr = 4'h8; pwdata = 32'h5; step();
    penable = 1; rd_req = 1; rd_addr = 16'h0015; step();
    psel = 0; penable = 0; pwrite = 0; rd_req = 0; step();
    apb_rd(8, "R8 set wins");
    apb_wr(8, 32'h5); apb_rd(8, "R8 cleared");
    // R9 disabled passes window
    apb_wr(8, 0); fuse_rd(16'h0015); apb_rd(8, "R9");
    // R4 R10 bus reset keeps seal and bounds
    apb_wr(8, 1); fuse_rd(16'h0011);
    presetn = 0; step(); step(); presetn = 1; step();
    apb_rd(8, "R10"); apb_rd(0, "R4 lo kept"); apb_rd(4, "R4 hi kept");
    apb_wr(0, 16'h0100); apb_rd(0, "R4 still sealed");
    // R4 power-on reset clears seal
    por_n = 0; presetn = 0; step(); step(); por_n = 1; presetn = 1; step();
    apb_rd(8, "R4 por"); apb_wr(0, 16'h0200); apb_rd(0, "R4 unsealed");
    step();
    finish_run();
  end
endmodule